// File: doc/BRIEF.md
# Lane-Partitioned 128-bit Add/Subtract Datapath

This block is a 128-bit integer datapath that adds or subtracts two operand words lane by lane. A 3-bit size code, chosen per operation, splits the word into sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes, two 64-bit lanes or one 128-bit lane. Every lane computes its own sum or difference modulo its width. No carry crosses from one lane into the next.

The adder array is built from sixteen 8-bit carry-select segments. Each segment computes its sum twice, once for a carry-in of 0 and once for a carry-in of 1. It then picks one result with the carry arriving from the segment below. A decoder derived from the size code marks which segments start a lane. At such a segment the carry from below is replaced by the lane's initial carry, which is 0 for addition and 1 for subtraction. Subtraction inverts operand B. A single adder array therefore serves every partitioning.

An operation is presented with a valid strobe. One clock later the registered result, the sixteen segment carry-out flags and an output valid appear. The flag of the top segment of each lane is that lane's carry-out. All other flags are internal segment carries.

Top module: `lane_addsub`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears out_valid, result and lane_cout to zero.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high and 0 in the cycle after a cycle with in_valid low. result and lane_cout reflect the inputs sampled at that in_valid edge.
- R3: When in_valid is low at a clock edge, result and lane_cout keep their values, whatever opa, opb, size_code and sub carry.
- R4: size_code 0 selects sixteen 8-bit lanes. Bits [8k+7:8k] of result equal the sum or difference of the same bits of opa and opb modulo 256, with no carry between lanes.
- R5: size_code 1, 2 and 3 select lanes of 16, 32 and 64 bits respectively. Each lane is computed modulo 2 to the power of its width, and carries ripple across the 8-bit segments inside a lane only.
- R6: size_code 4 selects one 128-bit lane. The carry propagates across all sixteen segments.
- R7: sub=1 gives opa minus opb per lane, computed as opa plus the inverted opb plus 1. The lane carry-out is then 1 exactly when the lane's unsigned opa is at least its opb, so 0 signals a borrow.
- R8: For sub=0, lane_cout bit (w/8)*(k+1)-1 is the unsigned carry-out of lane k of width w.
- R9: size_code values 5, 6 and 7 behave exactly like size_code 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are sampled on this edge |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| size_code | input | 3 | Lane width: 0=8, 1=16, 2=32, 3=64, 4..7=128 bits |
| sub | input | 1 | 0 selects add, 1 selects subtract (A minus B) |
| out_valid | output | 1 | Registered result is from an operation accepted last cycle |
| result | output | 128 | Registered lane-wise sum or difference |
| lane_cout | output | 16 | Registered carry-out of each 8-bit segment; lane tops are the lane carries |

## Verification
The hardest situation to reach is a carry chain that is only correct because it is cut at exactly the right segment. A random operand rarely produces a carry long enough to show a missing or misplaced lane cut. The stimulus therefore uses all-ones operands added to one, and zero minus one. These produce a carry or borrow at every bit position, so any segment that wrongly passes or blocks its carry corrupts a visible result byte. The same extreme patterns are repeated under every size code, including the codes that must fold onto 128 bits.

// File: rtl/lane_pkg.sv
// Package: shared lane-size encoding for the partitioned add/subtract datapath.
// Assumes lane widths are the segment width times a power of two.
package lane_pkg;
    typedef enum logic [2:0] {
        LANE_8   = 3'd0,
        LANE_16  = 3'd1,
        LANE_32  = 3'd2,
        LANE_64  = 3'd3,
        LANE_128 = 3'd4
    } lane_size_e;
endpackage

// File: rtl/lane_mask_dec.sv
// Module: lane_mask_dec
// Marks each segment that is the lowest segment of a lane for the given size code.
// Assumes NSEG is a power of two; codes above log2(NSEG) clamp to one full lane.
module lane_mask_dec #(
    parameter int unsigned NSEG = 16
) (
    input  logic [2:0]      size_code,
    output logic [NSEG-1:0] seg_head
);
    localparam int unsigned LOG_NSEG = $clog2(NSEG);

    logic [2:0]          lg_c;
    logic [LOG_NSEG-1:0] low_mask;

    // Clamp the size code to the widest legal partition.
    always_comb lg_c = (size_code > 3'(LOG_NSEG)) ? 3'(LOG_NSEG) : size_code;

    // Segments per lane minus one: the index bits that must be zero at a lane head.
    always_comb low_mask = LOG_NSEG'((32'd1 << lg_c) - 32'd1);

    for (genvar g = 0; g < NSEG; g++) begin : g_head
        assign seg_head[g] = ((LOG_NSEG'(g)) & low_mask) == '0;
    end
endmodule

// File: rtl/csel_segment.sv
// Module: csel_segment
// One carry-select adder segment: precomputes sums for both carry-in values, then selects.
// Assumes the caller has already inverted B for subtraction.
module csel_segment #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] sum_c0;
    logic [W:0] sum_c1;

    // Speculative sum assuming no incoming carry.
    always_comb sum_c0 = {1'b0, a} + {1'b0, b};

    // Speculative sum assuming an incoming carry.
    always_comb sum_c1 = {1'b0, a} + {1'b0, b} + (W+1)'(1);

    // Late carry picks the ready speculative result.
    always_comb {cout, sum} = cin ? sum_c1 : sum_c0;
endmodule

// File: rtl/lane_addsub.sv
// Module: lane_addsub (top)
// Lane-partitioned add/subtract over a DATA_W word built from SEG_W-bit carry-select
// segments; the carry chain is cut at lane heads, where the lane's initial carry enters.
// Result and per-segment carries are registered one cycle after in_valid.
// Assumes DATA_W is SEG_W times a power of two.
module lane_addsub #(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned SEG_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        opa,
    input  logic [DATA_W-1:0]        opb,
    input  logic [2:0]               size_code,
    input  logic                     sub,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        result,
    output logic [DATA_W/SEG_W-1:0]  lane_cout
);
    import lane_pkg::*;

    localparam int unsigned NSEG = DATA_W / SEG_W;

    logic [DATA_W-1:0] b_eff;
    logic [NSEG-1:0]   seg_head;
    logic [NSEG-1:0]   seg_cin;
    logic [NSEG-1:0]   seg_cout;
    logic [DATA_W-1:0] sum_c;

    // Subtraction adds the one's complement of B; the +1 enters as the lane carry.
    always_comb b_eff = sub ? ~opb : opb;

    lane_mask_dec #(.NSEG(NSEG)) u_dec (
        .size_code (size_code),
        .seg_head  (seg_head)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        if (g == 0) begin : g_first
            // The lowest segment always starts a lane.
            assign seg_cin[g] = sub;
        end else begin : g_rest
            // Lane heads take the initial carry, others chain from below.
            assign seg_cin[g] = seg_head[g] ? sub : seg_cout[g-1];
        end

        csel_segment #(.W(SEG_W)) u_seg (
            .a    (opa[g*SEG_W +: SEG_W]),
            .b    (b_eff[g*SEG_W +: SEG_W]),
            .cin  (seg_cin[g]),
            .sum  (sum_c[g*SEG_W +: SEG_W]),
            .cout (seg_cout[g])
        );
    end

    // Output valid tracks the input strobe with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture result and segment carries only for accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            lane_cout <= '0;
        end else if (in_valid) begin
            result    <= sum_c;
            lane_cout <= seg_cout;
        end
    end
endmodule

// File: rtl/lane_addsub_chk.sv
// Module: lane_addsub_chk
// Property checker for lane_addsub, attached with bind below.
module lane_addsub_chk #(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned SEG_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [DATA_W-1:0]        opa,
    input logic [DATA_W-1:0]        opb,
    input logic [2:0]               size_code,
    input logic                     sub,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        result,
    input logic [DATA_W/SEG_W-1:0]  lane_cout
);
    localparam int unsigned NSEG = DATA_W / SEG_W;

    // R1: reset clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && lane_cout == '0));

    // R2: out_valid follows in_valid by one cycle
    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: idle cycles hold the result and carries
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(lane_cout)));

    // R4: lowest 8-bit lane adds without carry-in
    p_low_byte_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 3'd0 && !sub) |=>
        result[SEG_W-1:0] == SEG_W'($past(opa[SEG_W-1:0]) + $past(opb[SEG_W-1:0])));

    // R6 and R7: full-width subtract matches word difference
    p_full_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code >= 3'd4 && sub) |=>
        result == DATA_W'($past(opa) - $past(opb)));

    // R8: full-width add top carry is the unsigned overflow
    p_full_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code >= 3'd4 && !sub) |=>
        lane_cout[NSEG-1] == (($past(opa) + $past(opb)) < $past(opa)));
endmodule

bind lane_addsub lane_addsub_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .size_code (size_code),
    .sub       (sub),
    .out_valid (out_valid),
    .result    (result),
    .lane_cout (lane_cout)
);

// File: tb/lane_addsub_test.sv
// Directed bench for lane_addsub: one task per scenario, each checking its own results.
module lane_addsub_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] opa, opb;
    logic [2:0]   size_code;
    logic         sub;
    logic         out_valid;
    logic [127:0] result;
    logic [15:0]  lane_cout;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lane_addsub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .size_code(size_code), .sub(sub), .out_valid(out_valid),
        .result(result), .lane_cout(lane_cout)
    );

    // Reference: per-lane arithmetic from the requirements.
    function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                  input logic [2:0] code, input logic s,
                                  output logic [127:0] r, output logic [15:0] tops,
                                  output logic [15:0] flg);
        int lg;
        int w;
        int nl;
        lg = (code > 3'd4) ? 4 : int'(code);
        w  = 8 << lg;
        nl = 128 / w;
        r = '0; tops = '0; flg = '0;
        for (int l = 0; l < nl; l++) begin
            logic [128:0] m, al, bl, sm;
            m  = (w == 128) ? {1'b0, {128{1'b1}}} : ((129'd1 << w) - 129'd1);
            al = ({1'b0, a} >> (l * w)) & m;
            bl = ({1'b0, b} >> (l * w)) & m;
            if (s) bl = (~bl) & m;
            sm = al + bl + {128'd0, s};
            r  = r | 128'((sm & m) << (l * w));
            tops[((l + 1) * w / 8) - 1] = 1'b1;
            flg[((l + 1) * w / 8) - 1]  = sm[w];
        end
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one operation and compare the registered outputs one edge later.
    task automatic apply(input string req, input logic [127:0] a, input logic [127:0] b,
                         input logic [2:0] code, input logic s);
        logic [127:0] er;
        logic [15:0]  et, ef;
        @(negedge clk);
        opa = a; opb = b; size_code = code; sub = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(a, b, code, s, er, et, ef);
        vectors++;
        if (result !== er || (lane_cout & et) !== ef || out_valid !== 1'b1) begin
            miscompares++;
            $display("FAIL %s: actual res=%h cout=%h vld=%b expected res=%h cout=%h vld=1",
                     req, result, lane_cout & et, out_valid, er, ef);
        end
    endtask

    task automatic t_reset;   // R1
        rst_n = 1'b0; in_valid = 1'b1; opa = '1; opb = '1; size_code = 3'd0; sub = 1'b0;
        repeat (3) @(negedge clk);
        vectors++;
        if (result !== '0 || lane_cout !== '0 || out_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: actual res=%h cout=%h vld=%b expected all zero",
                     result, lane_cout, out_valid);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_bytes;   // R4, R8
        apply("R4", {16{8'hFF}}, {16{8'h01}}, 3'd0, 1'b0);
        apply("R4", 128'h00112233_44556677_8899AABB_CCDDEEFF,
                    128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 3'd0, 1'b0);
        apply("R8", {8{8'h80, 8'h7F}}, {8{8'h80, 8'h01}}, 3'd0, 1'b0);
    endtask

    task automatic t_mid;     // R5
        for (int c = 1; c <= 3; c++) begin
            apply("R5", {16{8'hFF}}, 128'h00010001_00010001_00010001_00010001, 3'(c), 1'b0);
            apply("R5", {16{8'hFF}}, {16{8'h01}}, 3'(c), 1'b0);
        end
    endtask

    task automatic t_full;    // R6
        apply("R6", {128{1'b1}}, 128'd1, 3'd4, 1'b0);
        apply("R6", {64'h0, {64{1'b1}}}, 128'd1, 3'd4, 1'b0);
    endtask

    task automatic t_sub;     // R7
        for (int c = 0; c <= 4; c++) begin
            apply("R7", '0, {16{8'h01}}, 3'(c), 1'b1);
            apply("R7", {16{8'h05}}, {16{8'h05}}, 3'(c), 1'b1);
        end
    endtask

    task automatic t_fold;    // R9
        for (int c = 5; c <= 7; c++) begin
            apply("R9", {128{1'b1}}, 128'd1, 3'(c), 1'b0);
            apply("R9", '0, 128'd1, 3'(c), 1'b1);
        end
    endtask

    task automatic t_random;  // R2, R4, R5, R6, R7
        for (int i = 0; i < 40; i++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            apply("R2", a, b, 3'($urandom_range(0, 7)), 1'($urandom));
        end
    endtask

    task automatic t_hold;    // R3, R2
        logic [127:0] keep_r;
        logic [15:0]  keep_c;
        apply("R3", {16{8'hFF}}, {16{8'h01}}, 3'd0, 1'b0);
        keep_r = result; keep_c = lane_cout;
        opa = 128'h1234; opb = '1; size_code = 3'd4; sub = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R2", out_valid, 1'b0);
        vectors++;
        if (result !== keep_r || lane_cout !== keep_c) begin
            miscompares++;
            $display("FAIL R3: actual res=%h cout=%h expected res=%h cout=%h",
                     result, lane_cout, keep_r, keep_c);
        end
    endtask

    initial begin
        t_reset();
        t_bytes();
        t_mid();
        t_full();
        t_sub();
        t_fold();
        t_random();
        t_hold();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule